// File: doc/BRIEF.md
# Thermal and Battery Fault Supervisor

This block guards a line switch controller against two fault conditions. It samples a signed die temperature code and a signed battery voltage code on every clock, and runs a hysteretic trip on each. The result is one all-off override that the switch controller obeys. The controller itself, the sensors and the converters sit outside this block.

The block also models a bidirectional shutdown pin. While the thermal trip is active, the block enables an open-drain pull-down on the pin, so the pin reads low. Otherwise an internal pull-up makes it read high. Outside logic can affect the pin in two ways. Pulling the pin low requests all-off at once. Driving it high disables the thermal trip. When the pin is left floating, both checks behave normally.

Temperature codes are in degrees Celsius. Battery codes are in volts, and battery voltage is normally negative. Both are two's-complement integers.

Top module: `fault_supervisor`

## Requirements
- R1: While rst_ni is low, both fault flags are held clear, whatever the input codes are. As a result pd_en_o is 0 and pin_level_o is 1, and all_off_o follows only an external pull-low.
- R2: The thermal flag sets on the first rising clock edge at which temp_code_i >= TRIP_TEMP (default 125). A code one below the threshold does not set it.
- R3: Once set, the thermal flag stays set while temp_code_i >= TRIP_TEMP - TEMP_HYST (default 110). It clears on the first edge at which the code is below that level (default 109 or less).
- R4: The battery flag sets on the first edge at which batt_code_i > BATT_TRIP (default -10). A code equal to BATT_TRIP does not set it. A lost battery (code 0) therefore sets it.
- R5: Once set, the battery flag stays set while batt_code_i >= BATT_CLR (default -15). It clears on the first edge at which the code is below BATT_CLR.
- R6: While the thermal flag is set and the thermal trip is enabled, pd_en_o is 1 and pin_level_o is 0.
- R7: pin_drive_lo_i = 1 forces all_off_o = 1 and pin_level_o = 0 in the same cycle, without waiting for a clock edge, in reset as well as in operation.
- R8: pin_drive_hi_i = 1 with pin_drive_lo_i = 0 disables the thermal trip. In that case pd_en_o is 0, pin_level_o is 1, and the thermal flag does not raise all_off_o. The battery trip still raises all_off_o.
- R9: When pin_drive_lo_i and pin_drive_hi_i are both 1, the drive-low request wins. all_off_o is 1, pin_level_o is 0, and the thermal trip stays enabled.
- R10: all_off_o is 1 exactly when at least one of these holds: an external pull-low, an enabled thermal flag, or the battery flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_code_i | input | TEMP_W | Signed die temperature, degrees Celsius |
| batt_code_i | input | BATT_W | Signed battery voltage, volts |
| pin_drive_lo_i | input | 1 | External driver pulls the shutdown pin low |
| pin_drive_hi_i | input | 1 | External driver pulls the shutdown pin high |
| pd_en_o | output | 1 | Enable for the internal open-drain pull-down on the pin |
| pin_level_o | output | 1 | Resolved logic level of the shutdown pin |
| all_off_o | output | 1 | All-off override sent to the switch controller |

## Verification
A flag stuck in the wrong state shows up one cycle after the code crosses a threshold. all_off_o or pd_en_o then keeps its old value when it should change. Inside the hysteresis band the symptom is the reverse: an output that should hold steady toggles instead. Both codes are swept one step at a time, upward and back down, across every set and clear level, so an off-by-one comparison shows up at the exact code where it matters. Every combination of the pin drives is applied with the thermal flag set and with it clear. A wrong priority or a wrong mask therefore appears in the same cycle on all_off_o or pin_level_o.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;

  typedef enum logic [1:0] {
    PIN_FLOAT = 2'd0,
    PIN_LOW   = 2'd1,
    PIN_HIGH  = 2'd2
  } pin_mode_e;

  // drive-low has priority over drive-high
  function automatic pin_mode_e decode_pin(input logic drv_lo, input logic drv_hi);
    if (drv_lo)      return PIN_LOW;
    else if (drv_hi) return PIN_HIGH;
    else             return PIN_FLOAT;
  endfunction

endpackage

// File: rtl/fault_hyst_trip.sv
module fault_hyst_trip #(
  parameter int W       = 9,
  parameter int SET_LVL = 125,
  parameter int CLR_LVL = 110,
  parameter bit STRICT  = 1'b0   // 1: set on code > SET_LVL, 0: set on code >= SET_LVL
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] code_i,
  output logic                flag_o
);

  logic set_hit, clr_hit;
  int   code_int;

  assign code_int = int'(code_i);

  generate
    if (STRICT) begin : g_gt
      assign set_hit = code_int > SET_LVL;
    end else begin : g_ge
      assign set_hit = code_int >= SET_LVL;
    end
  endgenerate

  assign clr_hit = code_int < CLR_LVL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (set_hit) flag_o <= 1'b1;
    else if (clr_hit) flag_o <= 1'b0;
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i) !rst_ni |=> !flag_o);

  // R2 / R4: rising only after an over-threshold sample
  assert_rise_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> (STRICT ? (int'($past(code_i)) > SET_LVL) : (int'($past(code_i)) >= SET_LVL)));

  // R3 / R5: falling only after a below-clear sample
  assert_fall_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> (int'($past(code_i)) < CLR_LVL));

  assert_band_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && code_int >= CLR_LVL) |=> flag_o);

endmodule

// File: rtl/fault_pin_model.sv
module fault_pin_model
  import fault_sup_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drv_lo_i,
  input  logic drv_hi_i,
  input  logic therm_flag_i,
  output logic pd_en_o,
  output logic pin_level_o,
  output logic force_off_o,
  output logic therm_en_o
);

  pin_mode_e mode;

  assign mode        = decode_pin(drv_lo_i, drv_hi_i);
  assign therm_en_o  = (mode != PIN_HIGH);
  assign pd_en_o     = therm_flag_i && therm_en_o;
  assign force_off_o = (mode == PIN_LOW);
  assign pin_level_o = !(force_off_o || pd_en_o);

  assert_pd_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_en_o |-> !pin_level_o);

  assert_hi_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_hi_i && !drv_lo_i) |-> (!pd_en_o && pin_level_o));

  assert_lo_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_lo_i |-> (force_off_o && !pin_level_o));

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int TEMP_W    = 9,
  parameter int BATT_W    = 8,
  parameter int TRIP_TEMP = 125,
  parameter int TEMP_HYST = 15,
  parameter int BATT_TRIP = -10,
  parameter int BATT_CLR  = -15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [TEMP_W-1:0] temp_code_i,
  input  logic signed [BATT_W-1:0] batt_code_i,
  input  logic                     pin_drive_lo_i,
  input  logic                     pin_drive_hi_i,
  output logic                     pd_en_o,
  output logic                     pin_level_o,
  output logic                     all_off_o
);

  localparam int TEMP_CLR = TRIP_TEMP - TEMP_HYST;

  logic therm_flag, batt_flag;
  logic force_off, therm_en;

  fault_hyst_trip #(
    .W(TEMP_W), .SET_LVL(TRIP_TEMP), .CLR_LVL(TEMP_CLR), .STRICT(1'b0)
  ) i_therm_trip (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(temp_code_i), .flag_o(therm_flag)
  );

  fault_hyst_trip #(
    .W(BATT_W), .SET_LVL(BATT_TRIP), .CLR_LVL(BATT_CLR), .STRICT(1'b1)
  ) i_batt_trip (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(batt_code_i), .flag_o(batt_flag)
  );

  fault_pin_model i_pin (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .drv_lo_i(pin_drive_lo_i), .drv_hi_i(pin_drive_hi_i),
    .therm_flag_i(therm_flag),
    .pd_en_o(pd_en_o), .pin_level_o(pin_level_o),
    .force_off_o(force_off), .therm_en_o(therm_en)
  );

  assign all_off_o = force_off || (therm_flag && therm_en) || batt_flag;

  assert_ext_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_lo_i |-> all_off_o);

  assert_batt_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_flag |-> all_off_o);

  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_drive_lo_i && !batt_flag && !pd_en_o) |-> !all_off_o);

endmodule

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [8:0] temp = 9'sd25;
  logic signed [7:0] batt = -8'sd48;
  logic              dlo = 1'b0, dhi = 1'b0;
  logic              pd_en, pin_lvl, all_off;

  int n_chk = 0, n_fail = 0;
  bit m_t = 1'b0, m_b = 1'b0;

  typedef struct {bit ao; bit pd; bit pl; string tag;} exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  fault_supervisor i_fault_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .temp_code_i(temp), .batt_code_i(batt),
    .pin_drive_lo_i(dlo), .pin_drive_hi_i(dhi),
    .pd_en_o(pd_en), .pin_level_o(pin_lvl), .all_off_o(all_off)
  );

  task automatic apply(input int t, input int b, input bit lo, input bit hi, input string tag);
    exp_t e;
    bit dis, pd;
    @(negedge clk);
    temp = 9'(t); batt = 8'(b); dlo = lo; dhi = hi;
    if (!rst_n) begin
      m_t = 1'b0; m_b = 1'b0;
    end else begin
      if (t >= 125) m_t = 1'b1; else if (t < 110) m_t = 1'b0;
      if (b > -10)  m_b = 1'b1; else if (b < -15) m_b = 1'b0;
    end
    dis  = hi && !lo;
    pd   = m_t && !dis;
    e.pd = pd;
    e.pl = !(lo || pd);
    e.ao = lo || pd || m_b;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string nm, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "all_off_o",   all_off, e.ao);
      cmp(e.tag, "pd_en_o",     pd_en,   e.pd);
      cmp(e.tag, "pin_level_o", pin_lvl, e.pl);
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    // R1: hot die and lost battery during reset
    apply(200, 0, 0, 0, "R1");
    apply(200, 0, 0, 0, "R1");
    apply(200, 0, 1, 0, "R7");
    apply(200, 0, 0, 1, "R1");
    @(negedge clk); rst_n = 1'b1;
    apply(25, -48, 0, 0, "R1");

    // R2 up sweep, R3 down sweep
    for (int t = 115; t <= 130; t++) apply(t, -48, 0, 0, "R2");
    for (int t = 130; t >= 100; t--) apply(t, -48, 0, 0, "R3");
    // R3: re-trip, then hold inside band
    apply(125, -48, 0, 0, "R2");
    for (int t = 124; t >= 110; t -= 2) apply(t, -48, 0, 0, "R3");
    apply(130, -48, 0, 0, "R6");
    apply(130, -48, 0, 0, "R6");

    // R8: pull high masks thermal
    apply(130, -48, 0, 1, "R8");
    apply(140, -48, 0, 1, "R8");
    apply(140, -5, 0, 1, "R8");
    apply(140, -48, 0, 1, "R8");
    apply(140, -20, 0, 1, "R8");
    // R9: both drives
    apply(140, -20, 1, 1, "R9");
    apply(60, -20, 1, 1, "R9");
    // R7: pull low with cool die
    apply(60, -20, 1, 0, "R7");
    apply(60, -20, 0, 0, "R10");

    // R4 up sweep, R5 down sweep
    for (int b = -20; b <= 0; b++) apply(60, b, 0, 0, "R4");
    for (int b = 0; b >= -20; b--) apply(60, b, 0, 0, "R5");
    apply(60, -10, 0, 0, "R4");
    apply(60, -9, 0, 0, "R4");
    apply(60, -15, 0, 0, "R5");
    apply(60, -16, 0, 0, "R5");

    // R10: both faults together then release one by one
    apply(130, 0, 0, 0, "R10");
    apply(130, -30, 0, 0, "R10");
    apply(100, -30, 0, 0, "R10");
    apply(100, -30, 0, 1, "R10");

    // async reset mid-run clears flags
    apply(130, 0, 0, 0, "R10");
    @(negedge clk); rst_n = 1'b0;
    apply(130, 0, 0, 0, "R1");
    @(negedge clk); rst_n = 1'b1;

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule